// File: doc/BRIEF.md
# Cross-Clock Indexed Buffer Read Bridge

This block lets logic running on one clock fetch a chosen entry from a small register file that belongs to logic running on a second, unrelated clock. The register file is written on the owner clock through a simple write port. The requester asks for an entry by giving an index and pulsing a start input. The bridge then runs a four-phase request/ready exchange between the two domains and returns the selected word, marked by a one-cycle valid pulse.

Only two single-bit flags cross between the domains: the request going one way and the ready flag coming back. Each one passes through a two-flop synchronizer clocked by the receiving domain. The index and the returned word are multi-bit, but they are never synchronized. Instead, the handshake order keeps them stable whenever the other side samples them. The requester fixes the index one cycle before it raises the request. The owner reads the index only after its synchronized copy of the request is high. The owner loads its output word in the same edge that raises ready, and it keeps that word fixed until it sees the request fall. Each crossing therefore costs about two cycles of the receiving clock.

Top module: `xdom_buf_read_bridge`

## Requirements
- R1: After either reset, `rd_busy` and `rd_valid` are 0, and the requester accepts a new start once both resets are released.
- R2: A pulse on `wr_en` writes `wr_data` into entry `wr_idx` on an owner clock edge. A later read of that index returns that value on `rd_data` in the cycle where `rd_valid` is 1.
- R3: After an accepted `rd_start`, `rd_busy` is 1 from the next requester cycle until the handshake has fully returned to idle. `rd_valid` is a single-cycle pulse and is only ever high while `rd_busy` is 1.
- R4: A `rd_start` that arrives while `rd_busy` is 1 is ignored. The transfer in progress completes with its original index and produces exactly one `rd_valid`.
- R5: `rd_data` changes only in a cycle where `rd_valid` is 1. A write into the register file after a read has completed leaves `rd_data` unchanged until the next read.
- R6: The request flag rises only after the index register has been loaded in an earlier cycle, and the request is never raised while the synchronized ready flag is still high.
- R7: Changing `rd_idx` while `rd_busy` is 1 has no effect on the data returned for the transfer in progress.
- R8: On the owner side, the ready flag rises only after the synchronized request has been seen high. The owner output word holds constant for as long as ready stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| own_clk | input | 1 | Clock of the register-file owner |
| own_rst_n | input | 1 | Asynchronous active-low reset, owner domain |
| wr_en | input | 1 | Write strobe for the register file |
| wr_idx | input | IDX_W | Entry written when `wr_en` is 1 |
| wr_data | input | DATA_W | Word written when `wr_en` is 1 |
| req_clk | input | 1 | Clock of the requester |
| req_rst_n | input | 1 | Asynchronous active-low reset, requester domain |
| rd_idx | input | IDX_W | Entry to read, sampled when a start is accepted |
| rd_start | input | 1 | Start a read; accepted only while idle |
| rd_busy | output | 1 | A read exchange is in progress |
| rd_valid | output | 1 | One-cycle pulse: `rd_data` holds the returned word |
| rd_data | output | DATA_W | Last word returned |

## Verification
The hardest situation to create from the ports is a change of stimulus in the middle of an exchange: a second start and a new index presented while the request and ready flags are still travelling through the synchronizers. The bench holds `rd_start` high for several cycles just after a start has been accepted, and it switches `rd_idx` during that time. It then counts `rd_valid` pulses until `rd_busy` falls and compares the returned word against the entry chosen first. The two clocks run at unrelated periods, so the crossing points slide from one transfer to the next. The sweep reads every entry under two different fill patterns, reading them in ascending order for one pattern and descending order for the other.

// File: rtl/xbr_pkg.sv
package xbr_pkg;

  typedef enum logic [1:0] {
    RQ_IDLE  = 2'd0,
    RQ_SETUP = 2'd1,
    RQ_WAIT  = 2'd2,
    RQ_DRAIN = 2'd3
  } rq_state_e;

  typedef enum logic {
    OW_IDLE = 1'b0,
    OW_HOLD = 1'b1
  } ow_state_e;

endpackage

// File: rtl/xbr_sync2.sv
module xbr_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta_q;
  logic stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      stab_q <= 1'b0;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;
endmodule

// File: rtl/xbr_own_side.sv
module xbr_own_side
  import xbr_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int DATA_W      = 8,
  parameter int IDX_W       = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              req_s,
  input  logic [IDX_W-1:0]  sel_idx,
  output logic              rdy,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] rf_q [NUM_ENTRIES];
  logic [DATA_W-1:0] sel_word;

  ow_state_e         st_q, st_d;
  logic              rdy_q, rdy_d;
  logic [DATA_W-1:0] dout_q, dout_d;

  // Register file, one clock-enabled word per entry
  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
    logic hit;
    assign hit = wr_en && (int'(wr_idx) == e);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   rf_q[e] <= '0;
      else if (hit) rf_q[e] <= wr_data;
    end
  end

  always_comb begin
    sel_word = '0;
    for (int e = 0; e < NUM_ENTRIES; e++)
      if (int'(sel_idx) == e) sel_word = rf_q[e];
  end

  always_comb begin
    st_d   = st_q;
    rdy_d  = rdy_q;
    dout_d = dout_q;
    case (st_q)
      OW_IDLE: if (req_s) begin
        dout_d = sel_word;
        rdy_d  = 1'b1;
        st_d   = OW_HOLD;
      end
      OW_HOLD: if (!req_s) begin
        rdy_d = 1'b0;
        st_d  = OW_IDLE;
      end
      default: st_d = OW_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= OW_IDLE;
      rdy_q  <= 1'b0;
      dout_q <= '0;
    end else begin
      st_q   <= st_d;
      rdy_q  <= rdy_d;
      dout_q <= dout_d;
    end
  end

  assign rdy  = rdy_q;
  assign dout = dout_q;

  // R8: ready only after the synchronized request was seen
  p_rdy_after_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_q) |-> $past(req_s));
  // R8: output word frozen while ready stays high
  p_dout_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_q && $past(rdy_q)) |-> $stable(dout_q));
  // R8: ready drops only once request is seen low
  p_rdy_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_q) |-> !$past(req_s));
endmodule

// File: rtl/xbr_req_side.sv
module xbr_req_side
  import xbr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic              rd_start,
  input  logic              rdy_s,
  input  logic [DATA_W-1:0] own_data,
  output logic              req,
  output logic [IDX_W-1:0]  idx,
  output logic              busy,
  output logic              valid,
  output logic [DATA_W-1:0] data
);
  rq_state_e         st_q, st_d;
  logic              req_q, req_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              valid_q, valid_d;

  always_comb begin
    st_d    = st_q;
    req_d   = req_q;
    idx_d   = idx_q;
    data_d  = data_q;
    valid_d = 1'b0;
    case (st_q)
      RQ_IDLE: if (rd_start) begin
        idx_d = rd_idx;
        st_d  = RQ_SETUP;
      end
      RQ_SETUP: begin
        req_d = 1'b1;
        st_d  = RQ_WAIT;
      end
      RQ_WAIT: if (rdy_s) begin
        data_d  = own_data;
        valid_d = 1'b1;
        req_d   = 1'b0;
        st_d    = RQ_DRAIN;
      end
      RQ_DRAIN: if (!rdy_s) st_d = RQ_IDLE;
      default: st_d = RQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= RQ_IDLE;
      req_q   <= 1'b0;
      idx_q   <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      req_q   <= req_d;
      idx_q   <= idx_d;
      data_q  <= data_d;
      valid_q <= valid_d;
    end
  end

  assign req   = req_q;
  assign idx   = idx_q;
  assign busy  = (st_q != RQ_IDLE);
  assign valid = valid_q;
  assign data  = data_q;

  // R3: valid lasts one cycle
  p_valid_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);
  // R3: valid only inside a busy exchange
  p_valid_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> busy);
  // R6 / R7: index already settled when request rises and held while high
  p_idx_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> $stable(idx_q));
  // R6: no new request while ready is still seen high
  p_no_early_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> !$past(rdy_s));
  // R5: returned word changes only with valid
  p_data_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> $stable(data_q));
endmodule

// File: rtl/xdom_buf_read_bridge.sv
module xdom_buf_read_bridge #(
  parameter int NUM_ENTRIES = 4,
  parameter int DATA_W      = 8,
  localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic              own_clk,
  input  logic              own_rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              req_clk,
  input  logic              req_rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic              rd_start,
  output logic              rd_busy,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  logic              req_flag, req_in_own;
  logic              rdy_flag, rdy_in_req;
  logic [IDX_W-1:0]  held_idx;
  logic [DATA_W-1:0] held_word;

  xbr_sync2 u_req_sync (
    .clk(own_clk), .rst_n(own_rst_n), .d(req_flag), .q(req_in_own)
  );

  xbr_sync2 u_rdy_sync (
    .clk(req_clk), .rst_n(req_rst_n), .d(rdy_flag), .q(rdy_in_req)
  );

  xbr_req_side #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_req (
    .clk(req_clk), .rst_n(req_rst_n),
    .rd_idx(rd_idx), .rd_start(rd_start),
    .rdy_s(rdy_in_req), .own_data(held_word),
    .req(req_flag), .idx(held_idx),
    .busy(rd_busy), .valid(rd_valid), .data(rd_data)
  );

  xbr_own_side #(.NUM_ENTRIES(NUM_ENTRIES), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_own (
    .clk(own_clk), .rst_n(own_rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .req_s(req_in_own), .sel_idx(held_idx),
    .rdy(rdy_flag), .dout(held_word)
  );
endmodule

// File: tb/sim_xdom_buf_read_bridge.sv
module sim_xdom_buf_read_bridge;
  localparam int REQ_PERIOD = 10;
  localparam int OWN_PERIOD = 14;
  localparam int N  = 4;
  localparam int DW = 8;
  localparam int IW = 2;

  logic own_clk = 0, req_clk = 0;
  logic own_rst_n = 0, req_rst_n = 0;
  logic wr_en = 0;
  logic [IW-1:0] wr_idx = '0;
  logic [DW-1:0] wr_data = '0;
  logic [IW-1:0] rd_idx = '0;
  logic rd_start = 0;
  logic rd_busy, rd_valid;
  logic [DW-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(REQ_PERIOD/2) req_clk = ~req_clk;
  always #(OWN_PERIOD/2) own_clk = ~own_clk;

  xdom_buf_read_bridge #(.NUM_ENTRIES(N), .DATA_W(DW)) u0 (
    .own_clk(own_clk), .own_rst_n(own_rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .req_clk(req_clk), .req_rst_n(req_rst_n),
    .rd_idx(rd_idx), .rd_start(rd_start),
    .rd_busy(rd_busy), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  function automatic logic [DW-1:0] pat(int k, int i);
    return DW'((i * 37 + k * 91 + 5) & 8'hff);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int i, logic [DW-1:0] v);
    @(negedge own_clk);
    wr_en = 1; wr_idx = IW'(i); wr_data = v;
    @(negedge own_clk);
    wr_en = 0;
  endtask

  // start a read, wait for valid and for idle; returns word and valid count
  task automatic rd(int i, int hold_cycles, int alt_idx,
                    output logic [DW-1:0] got, output int nvalid);
    int t;
    nvalid = 0;
    got = '0;
    @(negedge req_clk);
    rd_idx = IW'(i); rd_start = 1;
    @(negedge req_clk);
    check(rd_busy == 1, "R3 busy after start", int'(rd_busy), 1);
    for (int c = 0; c < hold_cycles; c++) begin
      rd_idx = IW'(alt_idx);
      if (rd_valid) begin nvalid++; got = rd_data; end
      @(negedge req_clk);
    end
    rd_start = 0;
    t = 0;
    while (rd_busy && t < 300) begin
      if (rd_valid) begin nvalid++; got = rd_data; end
      @(negedge req_clk);
      t++;
    end
    if (rd_valid) begin nvalid++; got = rd_data; end
    check(t < 300, "R3 busy returns low", t, 0);
  endtask

  initial begin
    logic [DW-1:0] g;
    int nv;
    repeat (3) @(negedge req_clk);
    // R1: reset state
    check(rd_busy == 0, "R1 busy in reset", int'(rd_busy), 0);
    check(rd_valid == 0, "R1 valid in reset", int'(rd_valid), 0);
    @(negedge own_clk); own_rst_n = 1;
    @(negedge req_clk); req_rst_n = 1;
    @(negedge req_clk);
    check(rd_busy == 0, "R1 busy after reset", int'(rd_busy), 0);

    // R2: pattern 0, ascending sweep
    for (int i = 0; i < N; i++) wr(i, pat(0, i));
    for (int i = 0; i < N; i++) begin
      rd(i, 0, i, g, nv);
      check(g == pat(0, i), "R2 read pattern0", int'(g), int'(pat(0, i)));
      check(nv == 1, "R3 one valid", nv, 1);
    end
    // R2: pattern 1, descending sweep
    for (int i = 0; i < N; i++) wr(i, pat(1, i));
    for (int i = N - 1; i >= 0; i--) begin
      rd(i, 0, i, g, nv);
      check(g == pat(1, i), "R2 read pattern1", int'(g), int'(pat(1, i)));
    end

    // R4 / R7: start held and index changed while busy
    for (int i = 0; i < N; i++) begin
      rd(i, 3, (i + 2) % N, g, nv);
      check(g == pat(1, i), "R7 index change ignored", int'(g), int'(pat(1, i)));
      check(nv == 1, "R4 extra start ignored", nv, 1);
    end

    // R5: write after read does not disturb returned word
    rd(1, 0, 1, g, nv);
    wr(1, 8'h5a);
    repeat (20) begin
      @(negedge req_clk);
      check(rd_valid == 0, "R5 no spurious valid", int'(rd_valid), 0);
    end
    check(rd_data == pat(1, 1), "R5 data held", int'(rd_data), int'(pat(1, 1)));
    rd(1, 0, 1, g, nv);
    check(g == 8'h5a, "R2 rewrite visible", int'(g), 'h5a);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge req_clk);
      cyc++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule